// File: doc/BRIEF.md
# Coefficient Power-of-Two Segmentation Unit

This unit takes signed two's-complement filter coefficients one at a time and splits each into a shift part and a multiplier part. The shift part is a signed power of two, given as an exponent, a sign and an enable, so a barrel shifter can apply it to a data sample. The multiplier part is a small non-negative residual, so the hardware multiplier sees a narrow operand whose polarity never changes. The residual plus the shift part always equals the original coefficient.

The exponent is found by a search that tests one candidate power per clock. For a coefficient of magnitude `|h|`, let `i` be the smallest index with `2^i >= |h|`. The search starts at `i = 0` and stops at `i`. For a positive value that is not a power of two, the shift part is `2^(i-1)`. For a negative value that is not a power of two, the shift part is `-2^i`. For an exact power of two, of either sign, the shift part is the coefficient itself.

Coefficients arrive on a valid/ready stream. Results leave on a valid/ready stream. Only one coefficient is in flight at a time.

Top module: `coef_seg_unit`

## Requirements
- R1: Every result satisfies `s + resid_o == h`. Here `s = 2^exp_o` when `shift_en_o=1, neg_o=0`, `s = -2^exp_o` when `shift_en_o=1, neg_o=1`, and `s = 0` when `shift_en_o=0`.
- R2: The residual is non-negative and strictly below `2^exp_o`. A positive power of two `h = 2^k` gives `exp_o=k`, `neg_o=0`, `shift_en_o=1`, `resid_o=0`.
- R3: A positive `h` that is not a power of two gives `neg_o=0` and `exp_o=i-1`, so `2^exp_o` is the largest power of two below `h`.
- R4: A negative `h` that is not a power of two gives `neg_o=1` and `exp_o=i`, so `2^exp_o` is the smallest power of two above `|h|`.
- R5: `h = 0` gives `shift_en_o=0`, `neg_o=0`, `exp_o=0` and `resid_o=0`.
- R6: A negative power of two `h = -2^k` gives `neg_o=1`, `exp_o=k`, `shift_en_o=1` and `resid_o=0`.
- R7: The most negative value `-2^(W-1)` gives `neg_o=1`, `exp_o=W-1` and `resid_o=0`.
- R8: `res_valid_o` rises exactly `i+1` rising edges after the edge that accepts the coefficient, with `i=0` for zero. That is never more than `W` edges.
- R9: `coef_ready_o` is high only when no coefficient is being searched and no result is pending. While `res_valid_o=1` and `res_ready_i=0`, all result outputs hold their values. Coefficient input values seen while not ready have no effect.
- R10: While reset is asserted, `res_valid_o=0` and `coef_ready_o=1`.
- R11: Results leave in the order their coefficients were accepted, one result per coefficient.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coef_i | input | W | Signed coefficient |
| coef_valid_i | input | 1 | Coefficient present |
| coef_ready_o | output | 1 | Unit can accept a coefficient |
| exp_o | output | EW = clog2(W) | Shift exponent |
| neg_o | output | 1 | Shift part is negative |
| shift_en_o | output | 1 | Shift part is non-zero |
| resid_o | output | W-1 | Non-negative multiplier residual |
| res_valid_o | output | 1 | Result present |
| res_ready_i | input | 1 | Consumer takes the result |

## Verification
Several internal faults show up at the ports, each within one result:
- An off-by-one in the search counter appears as a wrong exponent and a broken sum on the first non-trivial coefficient.
- A stuck or miscounted counter also moves the `res_valid_o` rise away from the edge that R8 predicts.
- A wrong branch choice between the positive and negative cases flips `neg_o` or makes the residual exceed `2^exp_o` on the first such value.
- Corrupt handshake state shows as `coef_ready_o` and `res_valid_o` high together, or as a result that changes while stalled.

Corner values and random values are checked against an independent model, under random back-pressure.

// File: rtl/coef_seg_pkg.sv
package coef_seg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_HOLD   = 2'd2
  } seg_state_e;
endpackage

// File: rtl/coef_seg_mag.sv
module coef_seg_mag #(
  parameter int W = 16
) (
  input  logic [W-1:0] coef_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o
);
  // -2^(W-1) wraps onto itself, which read unsigned is the correct magnitude
  always_comb begin
    neg_o = coef_i[W-1];
    mag_o = neg_o ? (~coef_i + W'(1)) : coef_i;
  end
endmodule

// File: rtl/coef_seg_search.sv
module coef_seg_search #(
  parameter int W  = 16,
  parameter int EW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          step_i,
  input  logic [W-1:0]  mag_i,
  output logic [EW-1:0] cnt_o,
  output logic          hit_o
);
  logic [EW-1:0] cnt_q;
  logic [W-1:0]  cand;

  always_comb begin
    cand  = W'(1) << cnt_q;
    hit_o = (cand >= mag_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= '0;
    else if (step_i && !hit_o) cnt_q <= cnt_q + EW'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/coef_seg_split.sv
module coef_seg_split #(
  parameter int W  = 16,
  parameter int EW = $clog2(W),
  parameter int RW = W - 1
) (
  input  logic [W-1:0]  coef_i,
  input  logic [W-1:0]  mag_i,
  input  logic          neg_i,
  input  logic [EW-1:0] cnt_i,
  output logic [EW-1:0] exp_o,
  output logic          sneg_o,
  output logic          en_o,
  output logic [RW-1:0] resid_o
);
  logic [W-1:0] pow_cur, pow_half, diff;
  logic         is_zero, is_pow;

  always_comb begin
    pow_cur  = W'(1) << cnt_i;
    pow_half = pow_cur >> 1;
    is_zero  = (mag_i == '0);
    is_pow   = (pow_cur == mag_i);
    exp_o    = cnt_i;
    sneg_o   = neg_i;
    en_o     = 1'b1;
    diff     = '0;
    if (is_zero) begin
      exp_o  = '0;
      sneg_o = 1'b0;
      en_o   = 1'b0;
    end else if (is_pow) begin
      diff = '0;
    end else if (neg_i) begin
      diff = coef_i + pow_cur;   // h + 2^i, in [0, 2^(i-1))
    end else begin
      exp_o = cnt_i - EW'(1);
      diff  = coef_i - pow_half; // h - 2^(i-1), in [0, 2^(i-1))
    end
    resid_o = diff[RW-1:0];
  end
endmodule

// File: rtl/coef_seg_unit.sv
module coef_seg_unit
  import coef_seg_pkg::*;
#(
  parameter int W  = 16,
  parameter int EW = $clog2(W),
  parameter int RW = W - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  coef_i,
  input  logic          coef_valid_i,
  output logic          coef_ready_o,
  output logic [EW-1:0] exp_o,
  output logic          neg_o,
  output logic          shift_en_o,
  output logic [RW-1:0] resid_o,
  output logic          res_valid_o,
  input  logic          res_ready_i
);
  seg_state_e    state_q;
  logic [W-1:0]  coef_q, mag;
  logic          neg_in, start, step, hit;
  logic [EW-1:0] cnt;
  logic [EW-1:0] sp_exp;
  logic          sp_neg, sp_en;
  logic [RW-1:0] sp_resid;

  assign start = (state_q == ST_IDLE) && coef_valid_i;
  assign step  = (state_q == ST_SEARCH);

  coef_seg_mag #(.W(W)) u_mag (
    .coef_i (coef_q),
    .mag_o  (mag),
    .neg_o  (neg_in)
  );

  coef_seg_search #(.W(W), .EW(EW)) u_search (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .step_i  (step),
    .mag_i   (mag),
    .cnt_o   (cnt),
    .hit_o   (hit)
  );

  coef_seg_split #(.W(W), .EW(EW), .RW(RW)) u_split (
    .coef_i  (coef_q),
    .mag_i   (mag),
    .neg_i   (neg_in),
    .cnt_i   (cnt),
    .exp_o   (sp_exp),
    .sneg_o  (sp_neg),
    .en_o    (sp_en),
    .resid_o (sp_resid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      coef_q     <= '0;
      exp_o      <= '0;
      neg_o      <= 1'b0;
      shift_en_o <= 1'b0;
      resid_o    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (coef_valid_i) begin
          coef_q  <= coef_i;
          state_q <= ST_SEARCH;
        end
        ST_SEARCH: if (hit) begin
          exp_o      <= sp_exp;
          neg_o      <= sp_neg;
          shift_en_o <= sp_en;
          resid_o    <= sp_resid;
          state_q    <= ST_HOLD;
        end
        ST_HOLD: if (res_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign coef_ready_o = (state_q == ST_IDLE);
  assign res_valid_o  = (state_q == ST_HOLD);
endmodule

// File: rtl/coef_seg_unit_chk.sv
module coef_seg_unit_chk #(
  parameter int W  = 16,
  parameter int EW = $clog2(W),
  parameter int RW = W - 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [W-1:0]  coef_i,
  input logic          coef_valid_i,
  input logic          coef_ready_o,
  input logic [EW-1:0] exp_o,
  input logic          neg_o,
  input logic          shift_en_o,
  input logic [RW-1:0] resid_o,
  input logic          res_valid_o,
  input logic          res_ready_i
);
  logic [W-1:0]        cap_q;
  logic                busy_q;
  logic [15:0]         lat_q;
  logic [W+1:0]        pow;
  logic signed [W+1:0] sval, tot, ref_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      busy_q <= 1'b0;
      lat_q  <= '0;
    end else if (coef_valid_i && coef_ready_o) begin
      cap_q  <= coef_i;
      busy_q <= 1'b1;
      lat_q  <= 16'd1;
    end else if (res_valid_o) begin
      busy_q <= 1'b0;
    end else if (busy_q && lat_q != 16'hffff) begin
      lat_q <= lat_q + 16'd1;
    end
  end

  always_comb begin
    pow     = (W+2)'(1) << exp_o;
    sval    = !shift_en_o ? '0 : (neg_o ? -$signed(pow) : $signed(pow));
    tot     = sval + $signed({3'b000, resid_o});
    ref_val = $signed({{2{cap_q[W-1]}}, cap_q});
  end

  assert_sum_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> tot == ref_val);

  assert_resid_narrow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && shift_en_o) |-> ({3'b000, resid_o} < pow));

  assert_zero_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !shift_en_o) |-> (resid_o == '0 && !neg_o && exp_o == '0));

  // counter includes the accepting edge, so the bound is W+1
  assert_latency_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> lat_q <= 16'(W + 1));

  assert_ready_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(coef_ready_o && res_valid_o));

  assert_hold_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(exp_o) && $stable(neg_o) && $stable(shift_en_o) && $stable(resid_o)));

  assert_reset_state_R10: assert property (@(posedge clk_i)
    !rst_ni |-> (!res_valid_o && coef_ready_o));
endmodule

bind coef_seg_unit coef_seg_unit_chk #(.W(W), .EW(EW), .RW(RW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .coef_i       (coef_i),
  .coef_valid_i (coef_valid_i),
  .coef_ready_o (coef_ready_o),
  .exp_o        (exp_o),
  .neg_o        (neg_o),
  .shift_en_o   (shift_en_o),
  .resid_o      (resid_o),
  .res_valid_o  (res_valid_o),
  .res_ready_i  (res_ready_i)
);

// File: tb/coef_seg_unit_tb.sv
module coef_seg_unit_tb;
  localparam int W  = 16;
  localparam int EW = $clog2(W);
  localparam int RW = W - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [W-1:0]  coef_i = '0;
  logic          coef_valid_i = 1'b0;
  logic          coef_ready_o;
  logic [EW-1:0] exp_o;
  logic          neg_o, shift_en_o, res_valid_o;
  logic [RW-1:0] resid_o;
  logic          res_ready_i = 1'b0;

  always #4 clk_i = ~clk_i;

  coef_seg_unit #(.W(W)) u_dut (.*);

  typedef struct {
    int h; int ex; bit ng; bit en; int rs; int lat; int acc; string tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  bit drv_done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic item_t model(input int h);
    item_t e;
    int mag, i;
    mag = (h < 0) ? -h : h;
    i = 0;
    while ((1 << i) < mag) i++;
    e.h = h; e.lat = i + 2; e.rs = 0; e.ng = 0; e.en = 1; e.ex = i;
    if (mag == 0) begin
      e.en = 0; e.ex = 0; e.tag = "R5";
    end else if ((1 << i) == mag) begin
      e.ng = (h < 0);
      e.tag = (h == -(1 << (W-1))) ? "R7" : (h < 0 ? "R6" : "R2");
    end else if (h > 0) begin
      e.ex = i - 1; e.rs = h - (1 << (i-1)); e.tag = "R3";
    end else begin
      e.ng = 1; e.rs = h + (1 << i); e.tag = "R4";
    end
    return e;
  endfunction

  task automatic send(input int h);
    item_t e;
    @(negedge clk_i);
    coef_i = h[W-1:0];
    coef_valid_i = 1'b1;
    while (!coef_ready_o) @(negedge clk_i);
    e = model(h);
    e.acc = cyc;
    q.push_back(e);
    @(negedge clk_i);
    coef_valid_i = 1'b0;
    coef_i = W'($urandom); // junk while idle, must not matter (R9)
  endtask

  // monitor / scoreboard
  initial begin
    item_t cur;
    bit seen = 0;
    int s;
    forever begin
      @(negedge clk_i);
      if (rst_ni && res_valid_o) begin
        chk(!coef_ready_o, "R9 ready low while result pending", coef_ready_o, 0);
        if (!seen) begin
          chk(q.size() > 0, "R11 result without accepted coefficient", q.size(), 1);
          if (q.size() > 0) begin
            cur = q.pop_front();
            seen = 1;
            chk(cyc - cur.acc == cur.lat, "R8 latency", cyc - cur.acc, cur.lat);
          end
        end else begin
          chk(1'b1, "R9 held", 0, 0);
        end
        if (seen) begin
          s = !shift_en_o ? 0 : (neg_o ? -(1 << exp_o) : (1 << exp_o));
          chk(s + int'(resid_o) == cur.h, "R1 s+m", s + int'(resid_o), cur.h);
          chk(int'(exp_o) == cur.ex, {cur.tag, " exp"}, exp_o, cur.ex);
          chk(neg_o == cur.ng, {cur.tag, " sign"}, neg_o, cur.ng);
          chk(shift_en_o == cur.en, {cur.tag, " enable"}, shift_en_o, cur.en);
          chk(int'(resid_o) == cur.rs, {cur.tag, " resid R11 order"}, resid_o, cur.rs);
        end
        res_ready_i = ($urandom_range(0, 2) != 0);
        if (res_ready_i) seen = 0;
      end else begin
        res_ready_i = $urandom_range(0, 1);
      end
    end
  end

  // driver
  initial begin
    int corners[$] = '{0, 1, -1, 2, -2, 3, -3, 5, -5, 7, -7, 64, -64, 100, -100,
                       (1 << (W-2)), (1 << (W-1)) - 1, -(1 << (W-1)),
                       -(1 << (W-1)) + 1, -(1 << (W-2)) - 1, (1 << (W-2)) + 1};
    #1;
    chk(res_valid_o == 1'b0, "R10 res_valid in reset", res_valid_o, 0);
    chk(coef_ready_o == 1'b1, "R10 ready in reset", coef_ready_o, 1);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    foreach (corners[k]) send(corners[k]);
    for (int k = 0; k < 200; k++) begin
      logic signed [W-1:0] r;
      r = W'($urandom);
      send(int'(r));
    end
    while (q.size() > 0 || res_valid_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    drv_done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!drv_done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule